// File: doc/BRIEF.md
# Message pending bit array

This block keeps a set of eight 32-bit pending words that record which message objects have seen an event. Each time the message engine reports an event for an object, one pending bit is set. The target word and bit come from the object's 8-bit pending number. A 4-bit location mode can instead take the word from the transmit or receive interrupt node pointer, so that transmit and receive events of the same object land in different places.

Software reads each pending word and clears bits in it through a simple register port. A write clears only the bits written as zero and leaves the bits written as one alone. Clearing one bit therefore needs no read-modify-write, and a hardware set in the same cycle is never lost. For every pending word the block also keeps a read-only index of its lowest set bit. The index follows the word in the same cycle that the word changes, and it is reported both on a flat output and through the read port.

Top module: `msg_pend_array`

## Requirements
- R1: When `loc_mode` is 4'h0, an event sets a bit in pending word `evt_pnum[7:5]`.
- R2: When `loc_mode` is 4'h0, the bit set is position `evt_pnum[4:0]` (0 to 31) of that word.
- R3: When `loc_mode` is 4'hF, the word is `evt_txnp[3:1]` for a transmit event (`evt_is_tx`=1) and `evt_rxnp[3:1]` for a receive event.
- R4: When `loc_mode` is 4'hF, the bit position is {np[0], evt_pnum[3:0]}, where np is the node pointer selected by R3: np[0]=0 picks bits 15..0 and np[0]=1 picks bits 31..16.
- R5: Every `loc_mode` value other than 4'hF places the bit as in R1 and R2, and the node pointers then have no effect.
- R6: A write to pending word k gives it the value (old AND `reg_wdata`): bits written 1 keep their value and bits written 0 are cleared.
- R7: When an event and a write hit the same word in one cycle, the next value is (old AND `reg_wdata`) OR the event bit, so the set wins over a clear of the same bit.
- R8: Each word's index equals the position of its lowest set bit, or 32 when the word is zero. It changes in the same cycle as the word. Word k's index is on `low_idx[6*k+5:6*k]`.
- R9: `reg_rdata` is combinational from `reg_addr`. With `reg_addr[3]`=0 it returns pending word `reg_addr[2:0]`. With `reg_addr[3]`=1 it returns that word's index, zero-extended to 32 bits. Writes to addresses with `reg_addr[3]`=1 change nothing.
- R10: Reset clears all pending bits, so every index reads 32. Without an event, no pending bit ever goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_valid | input | 1 | One-cycle strobe: a message event sets one pending bit |
| evt_is_tx | input | 1 | 1 for a transmit event, 0 for a receive event |
| evt_pnum | input | 8 | Pending number of the message object |
| evt_rxnp | input | 4 | Receive interrupt node pointer of the object |
| evt_txnp | input | 4 | Transmit interrupt node pointer of the object |
| loc_mode | input | 4 | Bit location mode: 4'hF splits the location between node pointer and pending number, other values use the pending number alone |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | 32 | Write data: 0 bits clear, 1 bits keep |
| reg_rdata | output | 32 | Read data selected by `reg_addr` |
| low_idx | output | 48 | Lowest-set-bit index of each of the eight words, 6 bits per word |

## Verification
An event or a write presented before a rising edge shows up in its pending word right after that edge. The index and the read data are combinational from the word, so they show the change in that same cycle. The bench drives the strobes on a falling edge and removes them on the next falling edge. The rising edge in between is the only one that sees them, and the bench reads back through the port after the removal, one edge after the stimulus. Reset goes through a two-flop synchronizer, so the bench waits several cycles after releasing `arst_n` before the first stimulus.

// File: rtl/msgp_pkg.sv
package msgp_pkg;

  // Location mode codes: only the split code selects node-pointer placement;
  // every other code falls back to pending-number placement.
  typedef enum logic [3:0] {
    LOC_PNUM  = 4'h0,
    LOC_SPLIT = 4'hF
  } loc_mode_e;

  localparam int unsigned MODE_W = 4;

endpackage

// File: rtl/msgp_rst_sync.sv
module msgp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/msgp_loc_decode.sv
module msgp_loc_decode
  import msgp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 32,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS),
  localparam int unsigned POS_W   = $clog2(REG_W),
  localparam int unsigned PN_W    = SEL_W + POS_W,
  localparam int unsigned NP_W    = SEL_W + 1,
  localparam int unsigned FLAT_W  = NUM_REGS * REG_W
) (
  input  logic              evt_valid,
  input  logic              evt_is_tx,
  input  logic [PN_W-1:0]   evt_pnum,
  input  logic [NP_W-1:0]   evt_rxnp,
  input  logic [NP_W-1:0]   evt_txnp,
  input  logic [MODE_W-1:0] loc_mode,
  output logic [FLAT_W-1:0] set_mask
);

  logic [NP_W-1:0]  np_sel;
  logic [SEL_W-1:0] word_sel;
  logic [POS_W-1:0] bit_sel;
  logic [PN_W-1:0]  flat_pos;

  // Node pointer of the event's direction.
  assign np_sel = evt_is_tx ? evt_txnp : evt_rxnp;

  always_comb begin
    if (loc_mode == LOC_SPLIT) begin
      word_sel = np_sel[NP_W-1:1];
      bit_sel  = {np_sel[0], evt_pnum[POS_W-2:0]};
    end else begin
      word_sel = evt_pnum[PN_W-1:POS_W];
      bit_sel  = evt_pnum[POS_W-1:0];
    end
  end

  assign flat_pos = {word_sel, bit_sel};

  // One-hot over the whole bit array, empty without an event.
  always_comb begin
    for (int i = 0; i < FLAT_W; i++) begin
      set_mask[i] = evt_valid && (flat_pos == PN_W'(i));
    end
  end

endmodule

// File: rtl/msgp_pend_bank.sv
module msgp_pend_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 32,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS),
  localparam int unsigned ADDR_W  = SEL_W + 1,
  localparam int unsigned FLAT_W  = NUM_REGS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] set_mask,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [FLAT_W-1:0] pend_flat
);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    logic             wr_hit;
    logic             set_hit;
    logic             word_en;
    logic [REG_W-1:0] word_d;
    logic [REG_W-1:0] word_q;
    logic [REG_W-1:0] set_w;

    assign set_w   = set_mask[k*REG_W +: REG_W];
    assign wr_hit  = reg_wr && !reg_addr[ADDR_W-1] &&
                     (reg_addr[SEL_W-1:0] == SEL_W'(k));
    assign set_hit = |set_w;
    assign word_en = wr_hit || set_hit;

    // Clear by zeros first, then merge the hardware set on top.
    always_comb begin
      if (wr_hit) begin
        word_d = (word_q & reg_wdata) | set_w;
      end else begin
        word_d = word_q | set_w;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign pend_flat[k*REG_W +: REG_W] = word_q;
  end

endmodule

// File: rtl/msgp_lowest_idx.sv
module msgp_lowest_idx #(
  parameter int unsigned REG_W  = 32,
  localparam int unsigned IDX_W = $clog2(REG_W) + 1
) (
  input  logic [REG_W-1:0] word,
  output logic [IDX_W-1:0] idx
);

  // Scan from the top so the last hit is the lowest set bit.
  always_comb begin
    idx = IDX_W'(REG_W);
    for (int b = REG_W - 1; b >= 0; b--) begin
      if (word[b]) begin
        idx = IDX_W'(b);
      end
    end
  end

endmodule

// File: rtl/msg_pend_array.sv
module msg_pend_array
  import msgp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 32,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS),
  localparam int unsigned POS_W   = $clog2(REG_W),
  localparam int unsigned IDX_W   = POS_W + 1,
  localparam int unsigned PN_W    = SEL_W + POS_W,
  localparam int unsigned NP_W    = SEL_W + 1,
  localparam int unsigned ADDR_W  = SEL_W + 1,
  localparam int unsigned FLAT_W  = NUM_REGS * REG_W
) (
  input  logic                      clk,
  input  logic                      arst_n,
  input  logic                      evt_valid,
  input  logic                      evt_is_tx,
  input  logic [PN_W-1:0]           evt_pnum,
  input  logic [NP_W-1:0]           evt_rxnp,
  input  logic [NP_W-1:0]           evt_txnp,
  input  logic [MODE_W-1:0]         loc_mode,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  output logic [NUM_REGS*IDX_W-1:0] low_idx
);

  logic              rst_n;
  logic [FLAT_W-1:0] set_mask;
  logic [FLAT_W-1:0] pend_flat;
  logic [SEL_W-1:0]  rd_sel;

  msgp_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  msgp_loc_decode #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W)
  ) u_loc_decode (
    .evt_valid (evt_valid),
    .evt_is_tx (evt_is_tx),
    .evt_pnum  (evt_pnum),
    .evt_rxnp  (evt_rxnp),
    .evt_txnp  (evt_txnp),
    .loc_mode  (loc_mode),
    .set_mask  (set_mask)
  );

  msgp_pend_bank #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W)
  ) u_pend_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_mask  (set_mask),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend_flat (pend_flat)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_idx
    msgp_lowest_idx #(
      .REG_W (REG_W)
    ) u_lowest (
      .word (pend_flat[k*REG_W +: REG_W]),
      .idx  (low_idx[k*IDX_W +: IDX_W])
    );
  end

  assign rd_sel = reg_addr[SEL_W-1:0];

  always_comb begin
    if (reg_addr[ADDR_W-1]) begin
      reg_rdata = REG_W'(low_idx[rd_sel*IDX_W +: IDX_W]);
    end else begin
      reg_rdata = pend_flat[rd_sel*REG_W +: REG_W];
    end
  end

endmodule

// File: rtl/msg_pend_array_chk.sv
module msg_pend_array_chk #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 32,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS),
  localparam int unsigned POS_W   = $clog2(REG_W),
  localparam int unsigned IDX_W   = POS_W + 1,
  localparam int unsigned PN_W    = SEL_W + POS_W,
  localparam int unsigned NP_W    = SEL_W + 1,
  localparam int unsigned ADDR_W  = SEL_W + 1,
  localparam int unsigned FLAT_W  = NUM_REGS * REG_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      evt_valid,
  input logic                      evt_is_tx,
  input logic [PN_W-1:0]           evt_pnum,
  input logic [NP_W-1:0]           evt_rxnp,
  input logic [NP_W-1:0]           evt_txnp,
  input logic [3:0]                loc_mode,
  input logic                      reg_wr,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [REG_W-1:0]          reg_wdata,
  input logic [FLAT_W-1:0]         pend_flat,
  input logic [NUM_REGS*IDX_W-1:0] low_idx
);

  logic [NP_W-1:0]  chk_np;
  logic [REG_W-1:0] pw [NUM_REGS];
  logic [IDX_W-1:0] iw [NUM_REGS];

  assign chk_np = evt_is_tx ? evt_txnp : evt_rxnp;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_view
    assign pw[k] = pend_flat[k*REG_W +: REG_W];
    assign iw[k] = low_idx[k*IDX_W +: IDX_W];

    // R8: empty word reports 32, a non-empty one never does
    a_r8_empty_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (pw[k] == '0) == (iw[k] == IDX_W'(REG_W)));

    // R8: a reported index always points at a set bit
    a_r8_idx_is_set: assert property (@(posedge clk) disable iff (!rst_n)
      (iw[k] < IDX_W'(REG_W)) |-> pw[k][iw[k][POS_W-1:0]]);
  end

  // R1, R2, R5: pending-number placement, flat position equals the number
  a_r1_direct_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && loc_mode != 4'hF) |=> pend_flat[$past(evt_pnum)]);

  // R3, R4: split placement from node pointer and low pending-number bits
  a_r3_split_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && loc_mode == 4'hF) |=>
      pend_flat[{$past(chk_np), $past(evt_pnum[POS_W-2:0])}]);

  // R6: a write without an event leaves old AND data
  a_r6_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr[ADDR_W-1] && !evt_valid) |=>
      pw[$past(reg_addr[SEL_W-1:0])] ==
        ($past(pw[reg_addr[SEL_W-1:0]]) & $past(reg_wdata)));

  // R9: writes to index addresses change no pending bit without an event
  a_r9_idx_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[ADDR_W-1] && !evt_valid) |=> $stable(pend_flat));

  // R10: no bit rises without an event
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |=> ((pend_flat & ~$past(pend_flat)) == '0));

  // R10: array is empty right after reset release
  a_r10_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend_flat == '0));

endmodule

bind msg_pend_array msg_pend_array_chk #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_is_tx (evt_is_tx),
  .evt_pnum  (evt_pnum),
  .evt_rxnp  (evt_rxnp),
  .evt_txnp  (evt_txnp),
  .loc_mode  (loc_mode),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pend_flat (pend_flat),
  .low_idx   (low_idx)
);

// File: tb/msg_pend_array_tb_top.sv
module msg_pend_array_tb_top;

  logic        clk;
  logic        arst_n;
  logic        evt_valid;
  logic        evt_is_tx;
  logic [7:0]  evt_pnum;
  logic [3:0]  evt_rxnp;
  logic [3:0]  evt_txnp;
  logic [3:0]  loc_mode;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [47:0] low_idx;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  msg_pend_array dut_i (
    .clk       (clk),
    .arst_n    (arst_n),
    .evt_valid (evt_valid),
    .evt_is_tx (evt_is_tx),
    .evt_pnum  (evt_pnum),
    .evt_rxnp  (evt_rxnp),
    .evt_txnp  (evt_txnp),
    .loc_mode  (loc_mode),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .low_idx   (low_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {is_tx, mode, pnum, rxnp, txnp, expected word, expected bit}
  localparam int NVEC = 8;
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 4'h0, 8'h00, 4'h0, 4'h0, 3'd0, 5'd0},   // R1 R2 lowest corner
    {1'b0, 4'h0, 8'hFF, 4'h5, 4'h9, 3'd7, 5'd31},  // R1 R2 highest corner
    {1'b1, 4'h0, 8'h6A, 4'hF, 4'hF, 3'd3, 5'd10},  // R1 R2 pointers ignored
    {1'b0, 4'h5, 8'hA3, 4'hE, 4'h6, 3'd5, 5'd3},   // R5 other mode code
    {1'b1, 4'hF, 8'h37, 4'h2, 4'hB, 3'd5, 5'd23},  // R3 R4 tx, high half
    {1'b0, 4'hF, 8'h37, 4'h2, 4'hB, 3'd1, 5'd7},   // R3 R4 rx, low half
    {1'b1, 4'hF, 8'hFF, 4'hF, 4'h0, 3'd0, 5'd15},  // R4 upper pnum bits unused
    {1'b0, 4'hF, 8'h10, 4'hF, 4'h0, 3'd7, 5'd16}   // R4 low nibble zero
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic fire(input logic tx, input logic [3:0] m, input logic [7:0] pn,
                      input logic [3:0] rxp, input logic [3:0] txp);
    @(negedge clk);
    evt_is_tx = tx; loc_mode = m; evt_pnum = pn;
    evt_rxnp = rxp; evt_txnp = txp; evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    arst_n = 1'b0; evt_valid = 1'b0; evt_is_tx = 1'b0; evt_pnum = '0;
    evt_rxnp = '0; evt_txnp = '0; loc_mode = '0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state, R9 and R8 empty index 32
    for (int k = 0; k < 8; k++) begin
      rd(4'(k), d);
      check("R10 reset word", d, 32'h0);
      rd(4'(8 + k), d);
      check("R8 R9 reset index", d, 32'd32);
    end

    // Table walk: one event, read word and index, then clear with zeros
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] ew;
      logic [4:0] eb;
      ew = VEC[v][7:5];
      eb = VEC[v][4:0];
      fire(VEC[v][28], VEC[v][27:24], VEC[v][23:16], VEC[v][15:12], VEC[v][11:8]);
      rd({1'b0, ew}, d);
      check("R1 R2 R3 R4 R5 placement", d, 32'h1 << eb);
      rd({1'b1, ew}, d);
      check("R8 R9 index after set", d, {27'h0, eb});
      wr({1'b0, ew}, 32'h0);
      rd({1'b0, ew}, d);
      check("R6 clear all", d, 32'h0);
    end

    // R6 selective clear: bits 3 and 9 in word 2, keep 9
    fire(1'b0, 4'h0, 8'h43, 4'h0, 4'h0);
    fire(1'b0, 4'h0, 8'h49, 4'h0, 4'h0);
    rd(4'd10, d);
    check("R8 lowest of two", d, 32'd3);
    wr(4'd2, ~32'h8);
    rd(4'd2, d);
    check("R6 write one keeps, zero clears", d, 32'h200);
    rd(4'd10, d);
    check("R8 index follows clear", d, 32'd9);
    rd(4'd0, d);
    check("R6 other word untouched", d, 32'h0);

    // R9 write to index address ignored
    wr(4'd10, 32'h0);
    rd(4'd2, d);
    check("R9 index write ignored", d, 32'h200);

    // R7 set and clear-all on the same word in one cycle
    @(negedge clk);
    evt_is_tx = 1'b0; loc_mode = 4'h0; evt_pnum = 8'h44;
    evt_valid = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h0; reg_wr = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0; reg_wr = 1'b0;
    rd(4'd2, d);
    check("R7 set survives clear", d, 32'h10);

    // R7 set and clear of the very same bit: set wins
    @(negedge clk);
    evt_pnum = 8'h44; evt_valid = 1'b1;
    reg_addr = 4'd2; reg_wdata = ~32'h10; reg_wr = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0; reg_wr = 1'b0;
    rd(4'd2, d);
    check("R7 same bit set wins", d, 32'h10);
    check("R8 flat index word 2", {26'h0, low_idx[17:12]}, 32'd4);

    // R7 event on another word during a write: both take effect
    @(negedge clk);
    evt_pnum = 8'hE1; evt_valid = 1'b1;
    reg_addr = 4'd2; reg_wdata = 32'h0; reg_wr = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0; reg_wr = 1'b0;
    rd(4'd2, d);
    check("R7 written word cleared", d, 32'h0);
    rd(4'd7, d);
    check("R7 other word set", d, 32'h2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule